// File: doc/BRIEF.md
# Address Decoder with Wait-State Generator

This block sits between the 16-bit address bus of a small 8-bit processor system and its memories and peripherals. It turns the address into one active-low chip select: a RAM select, one of two ROM window selects, or one of three I/O device selects. The ROM is split into a low window and a high window, with a 4 KB I/O page between them.

Read and write strobes are formed from the phase-2 clock level and the read/write line. A processor ready output is pulled low for a configurable number of clock cycles whenever ROM or an I/O device is addressed. The slow parts then get extra time while RAM still runs at full speed.

Once a stretched access has completed, ready stays high until the processor presents a different address or direction. A processor that re-samples the same bus cycle therefore is not stalled again.

Top module: `bus_decode_wait`

## Requirements
- R1: Addresses 0x0000 to 0xBFFF drive `ramSelN` low and no other select.
- R2: Addresses 0xC000 to 0xCFFF drive `romSelN[0]` low. Addresses 0xE000 to 0xFFFF drive `romSelN[1]` low.
- R3: The page 0xD000 to 0xDFFF is cut into four 1 KB slots by address bits [11:10]. Slot 0 drives `ioSelN[0]` (serial ports), slot 1 drives `ioSelN[1]` (clock/watchdog), and slot 2 drives `ioSelN[2]` (disk controller). Slot 3 drives no select.
- R4: At no address is more than one select low.
- R5: While `rstN` is low, every select, both strobes and `ready` are high, whatever the address, direction and `phi2`.
- R6: `rdStbN` is low exactly when `phi2` and `rdWrN` are both high. `wrStbN` is low exactly when `phi2` is high and `rdWrN` is low.
- R7: An access to RAM never pulls `ready` low.
- R8: A ROM or I/O access pulls `ready` low from its first cycle. It stays low for `waitCfg` rising clock edges, with a value of 0 taken as 1, and then returns high.
- R9: After a stretched access completes, `ready` stays high while the address and `rdWrN` are unchanged. A change of either starts a fresh wait if the new target is ROM or I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that paces wait states |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| rdWrN | input | 1 | High for read, low for write |
| phi2 | input | 1 | Phase-2 clock level |
| waitCfg | input | 2 | Wait cycles for slow accesses (0 acts as 1) |
| ramSelN | output | 1 | RAM chip select, active low |
| romSelN | output | 2 | ROM window selects, [0] low window, [1] high window |
| ioSelN | output | 3 | I/O device selects, active low |
| rdStbN | output | 1 | Qualified read strobe, active low |
| wrStbN | output | 1 | Qualified write strobe, active low |
| ready | output | 1 | Processor ready, low while a slow access is stretched |

## Verification
Selects and strobes are pure combinational functions of the inputs. They are due in the same cycle, so the bench drives them on the falling edge and samples two nanoseconds later. `ready` falls combinationally in the first cycle of a slow access and rises only after the N-th rising edge. The bench therefore samples it once per cycle, just before each rising edge, and expects low for the first N samples and high afterward. Holding the address for further cycles checks R9, and so does moving away and back.

// File: rtl/bus_decode_pkg.sv
package bus_decode_pkg;

  // Strobes from the wait control to the decode datapath.
  typedef struct packed {
    logic enable;  // out of reset
    logic stall;   // hold processor ready low this cycle
  } ctrl_t;

endpackage

// File: rtl/bus_decode_path.sv
module bus_decode_path
  import bus_decode_pkg::*;
#(
  parameter int DEC_W   = 6,
  parameter int SLOT_W  = 2,
  parameter int IO_DEVS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEC_W-1:0]   addrHi,
  input  logic               rdWrN,
  input  logic               phi2,
  input  ctrl_t              ctrl,
  output logic               ramSelN,
  output logic [1:0]         romSelN,
  output logic [IO_DEVS-1:0] ioSelN,
  output logic               rdStbN,
  output logic               wrStbN,
  output logic               ready,
  output logic               slowAccess
);

  localparam int NIB_W = DEC_W - SLOT_W;

  logic [NIB_W-1:0]  pageNib;
  logic [SLOT_W-1:0] ioSlot;
  logic ramHit, romLoHit, romHiHit, ioPageHit;
  logic [IO_DEVS-1:0] ioHit;

  assign pageNib = addrHi[DEC_W-1 -: NIB_W];
  assign ioSlot  = addrHi[SLOT_W-1:0];

  always_comb begin
    ramHit    = (pageNib < NIB_W'(4'hC));
    romLoHit  = (pageNib == NIB_W'(4'hC));
    ioPageHit = (pageNib == NIB_W'(4'hD));
    romHiHit  = (pageNib >= NIB_W'(4'hE));
  end

  for (genvar i = 0; i < IO_DEVS; i++) begin : g_ioDev
    assign ioHit[i] = ioPageHit && (ioSlot == SLOT_W'(i));
    assign ioSelN[i] = ~(ctrl.enable && ioHit[i]);
  end

  assign ramSelN    = ~(ctrl.enable && ramHit);
  assign romSelN[0] = ~(ctrl.enable && romLoHit);
  assign romSelN[1] = ~(ctrl.enable && romHiHit);

  assign slowAccess = romLoHit || romHiHit || ioPageHit;

  assign rdStbN = ~(ctrl.enable && phi2 && rdWrN);
  assign wrStbN = ~(ctrl.enable && phi2 && !rdWrN);
  assign ready  = ~(ctrl.enable && ctrl.stall);

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~ramSelN, ~romSelN, ~ioSelN}));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdStbN |-> wrStbN);

  assert_strobe_phase_R6: assert property (@(posedge clk) disable iff (!rstN)
    !phi2 |-> (rdStbN && wrStbN));

  assert_ram_fast_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ramSelN |-> ready);

endmodule

// File: rtl/bus_decode_ctrl.sv
module bus_decode_ctrl
  import bus_decode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWrN,
  input  logic              slowAccess,
  input  logic [WAIT_W-1:0] waitCfg,
  output ctrl_t             ctrl
);

  localparam int CNT_W = WAIT_W + 1;

  logic [WAIT_W-1:0] waitCnt;
  logic              doneFlag;
  logic [ADDR_W-1:0] lastAddr;
  logic              lastRdWrN;
  logic              sameCycle;
  logic              doneEff;
  logic              stall;
  logic [CNT_W-1:0]  cfgEff;
  logic              finishing;

  assign cfgEff    = (waitCfg == '0) ? CNT_W'(1) : {1'b0, waitCfg};
  assign sameCycle = (addr == lastAddr) && (rdWrN == lastRdWrN);
  assign doneEff   = doneFlag && sameCycle;
  assign stall     = rstN && slowAccess && !doneEff;
  assign finishing = stall && (({1'b0, waitCnt} + CNT_W'(1)) >= cfgEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt   <= '0;
      doneFlag  <= 1'b0;
      lastAddr  <= '0;
      lastRdWrN <= 1'b1;
    end else if (finishing) begin
      waitCnt   <= '0;
      doneFlag  <= 1'b1;
      lastAddr  <= addr;
      lastRdWrN <= rdWrN;
    end else if (stall) begin
      waitCnt <= waitCnt + WAIT_W'(1);
    end else begin
      waitCnt <= '0;
      if (!doneEff) doneFlag <= 1'b0;
    end
  end

  assign ctrl.enable = rstN;
  assign ctrl.stall  = stall;

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> ({1'b0, waitCnt} < cfgEff));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    finishing ##1 ($stable(addr) && $stable(rdWrN)) |-> !ctrl.stall);

endmodule

// File: rtl/bus_decode_wait.sv
module bus_decode_wait
  import bus_decode_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WAIT_W  = 2,
  parameter int IO_DEVS = 3,
  parameter int IO_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdWrN,
  input  logic               phi2,
  input  logic [WAIT_W-1:0]  waitCfg,
  output logic               ramSelN,
  output logic [1:0]         romSelN,
  output logic [IO_DEVS-1:0] ioSelN,
  output logic               rdStbN,
  output logic               wrStbN,
  output logic               ready
);

  localparam int SLOT_W = $clog2(IO_SLOTS);
  localparam int DEC_W  = 4 + SLOT_W;

  ctrl_t ctrl;
  logic  slowAccess;

  bus_decode_path #(
    .DEC_W(DEC_W), .SLOT_W(SLOT_W), .IO_DEVS(IO_DEVS)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .addrHi(addr[ADDR_W-1 -: DEC_W]),
    .rdWrN(rdWrN), .phi2(phi2), .ctrl(ctrl),
    .ramSelN(ramSelN), .romSelN(romSelN), .ioSelN(ioSelN),
    .rdStbN(rdStbN), .wrStbN(wrStbN), .ready(ready),
    .slowAccess(slowAccess)
  );

  bus_decode_ctrl #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdWrN(rdWrN),
    .slowAccess(slowAccess), .waitCfg(waitCfg), .ctrl(ctrl)
  );

endmodule

// File: tb/sim_bus_decode_wait.sv
`timescale 1ns/1ps
module sim_bus_decode_wait;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic rdWrN = 1'b1;
  logic phi2 = 1'b0;
  logic [1:0] waitCfg = 2'd1;
  logic ramSelN, rdStbN, wrStbN, ready;
  logic [1:0] romSelN;
  logic [2:0] ioSelN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_decode_wait u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .rdWrN(rdWrN), .phi2(phi2),
    .waitCfg(waitCfg), .ramSelN(ramSelN), .romSelN(romSelN),
    .ioSelN(ioSelN), .rdStbN(rdStbN), .wrStbN(wrStbN), .ready(ready)
  );

  // Active-high select vector: {ram, romHi, romLo, io2, io1, io0}
  function automatic logic [5:0] expSel(input logic [15:0] a);
    logic [5:0] e = '0;
    int page = a / 4096;
    int slot = (a % 4096) / 1024;
    if (page < 12) e[5] = 1'b1;
    else if (page == 12) e[3] = 1'b1;
    else if (page == 13) begin
      if (slot < 3) e[slot] = 1'b1;
    end else e[4] = 1'b1;
    return e;
  endfunction

  function automatic string reqOf(input logic [15:0] a);
    if (a < 16'hC000) return "R1";
    if (a >= 16'hD000 && a < 16'hE000) return "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] actSel();
    return {~ramSelN, ~romSelN[1], ~romSelN[0], ~ioSelN};
  endfunction

  // Present a new access and check ready over n+2 cycles (R8, R9).
  task automatic slowAccess(input logic [15:0] a, input logic rw,
                            input int n, input string req);
    @(negedge clk); addr = a; rdWrN = rw;
    for (int k = 0; k < n + 2; k++) begin
      if (k > 0) @(negedge clk);
      #2;
      check(req, ready, (k < n) ? 1'b0 : 1'b1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          errors++;
          checks++;
          $display("FAIL watchdog actual=timeout expected=done");
          $display("  CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    // R5: reset state
    addr = 16'hC123; phi2 = 1'b1; rdWrN = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check("R5 selects", actSel(), 6'b0);
    check("R5 ready", ready, 1'b1);
    check("R5 rdStb", rdStbN, 1'b1);
    rdWrN = 1'b0; #1;
    check("R5 wrStb", wrStbN, 1'b1);
    @(negedge clk); rstN = 1'b1; addr = 16'h0000; rdWrN = 1'b1;

    // R6: strobe truth table
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++) begin
        @(negedge clk); phi2 = p[0]; rdWrN = w[0]; #2;
        check("R6 rd", rdStbN, !(p[0] && w[0]));
        check("R6 wr", wrStbN, !(p[0] && !w[0]));
      end
    phi2 = 1'b0; rdWrN = 1'b1;

    // R1-R4 map sweep, every 16th address; R7 ready in RAM
    waitCfg = 2'd1;
    for (int a = 0; a < 65536; a += 16) begin
      @(negedge clk); addr = 16'(a); #2;
      check(reqOf(16'(a)), actSel(), expSel(16'(a)));
      check("R4 onehot", $countones(actSel()) <= 1, 1'b1);
      if (a < 16'hC000) check("R7 ram ready", ready, 1'b1);
    end
    // Slot edges of the I/O page
    foreach (addr[i]) ;
    begin
      logic [15:0] edges [8] = '{16'hD000, 16'hD3FF, 16'hD400, 16'hD7FF,
                                 16'hD800, 16'hDBFF, 16'hDC00, 16'hDFFF};
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); addr = edges[i]; #2;
        check("R3 edge", actSel(), expSel(edges[i]));
      end
    end

    // R8 wait lengths, 0 taken as 1, for ROM and I/O targets
    @(negedge clk); addr = 16'h1000;
    for (int c = 0; c < 4; c++) begin
      waitCfg = 2'(c);
      slowAccess(16'hC010, 1'b1, (c == 0) ? 1 : c, "R8 romLo");
      slowAccess(16'hD405, 1'b1, (c == 0) ? 1 : c, "R8 io");
      slowAccess(16'hFFFC, 1'b1, (c == 0) ? 1 : c, "R8 romHi");
    end

    // R9: hold, direction flip, leave and return
    waitCfg = 2'd3;
    slowAccess(16'hD800, 1'b1, 3, "R9 first");
    repeat (3) begin
      @(negedge clk); #2; check("R9 hold", ready, 1'b1);
    end
    slowAccess(16'hD800, 1'b0, 3, "R9 dirflip");
    @(negedge clk); addr = 16'h2000; rdWrN = 1'b1; #2;
    check("R7 ram between", ready, 1'b1);
    slowAccess(16'hD800, 1'b0, 3, "R9 return");

    // R7: RAM stays fast across many cycles
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); addr = 16'(i * 16'h1700); #2;
      check("R7 ram", ready, 1'b1);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule